// File: doc/BRIEF.md
# Machine-Cycle Pacing Unit

This block paces a processor core by producing a one-clock cycle-enable strobe. By default the strobe is high on every input clock, so the core runs at full rate. Software can stretch the machine cycle to 4, 64 or 1024 input clocks to save power when there is little work. The strobe then rises once per stretched cycle, and the core advances only on strobe clocks.

Software writes a small configuration register. It holds a two-bit speed field and a wake-enable bit. A newly written speed takes effect only at the end of the machine cycle already in progress. While the wake-enable bit is set, any interrupt request or any serial-activity indication drops the block to full rate at once. In that case the counter restarts, the speed field is cleared, and the core gets a strobe on the very next clock.

The four ratios are parameters. The interrupt and serial-activity inputs are vectors whose width is set by parameters. Any bit that is high counts as an event.

Top module: `cycle_pace_unit`

## Requirements
- R1: While `rst` is high, `cyc_en` is low. On the clock after `rst` is released, the speed field is 00 and `cyc_en` is high.
- R2: The speed field is `cfg_wdata[1:0]`. Its codes select the number of input clocks between successive rising `cyc_en` strobes: 00 gives 1, 01 gives 4, 10 gives 64 and 11 gives 1024.
- R3: When the active ratio is greater than one, `cyc_en` is high for exactly one clock per machine cycle.
- R4: A speed written while a machine cycle is in progress does not shorten or lengthen that cycle. The new ratio governs only the cycles that start after it ends.
- R5: The wake-enable bit is `cfg_wdata[2]`. While it is set, any high bit of `irq_req` makes `cyc_en` high on the following clock. From then on the ratio is 1 until software writes another speed.
- R6: While the wake-enable bit is set, any high bit of `ser_act` has the same effect as an interrupt request.
- R7: While the wake-enable bit is clear, `irq_req` and `ser_act` have no effect on the ratio or on the timing of `cyc_en`.
- R8: A wake event and a configuration write in the same clock leave the speed field at 00. The wake event wins over the written speed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for the configuration register |
| cfg_wdata | input | 3 | Configuration data: bits 1:0 hold the speed, bit 2 holds the wake enable |
| irq_req | input | N_IRQ | Interrupt request lines; any high bit is a wake event |
| ser_act | input | N_SER | Serial-port activity lines; any high bit is a wake event |
| cyc_en | output | 1 | Registered machine-cycle enable strobe |

## Verification
The bench builds the unit with its default ratios of 1, 4, 64 and 1024. With these values every speed code can be measured strobe to strobe, including the full 1024-clock cycle. Wake events can be injected deep inside a long cycle, where truncating that cycle is visible. A speed change written part-way through a 64-clock cycle shows whether the cycle still finishes at its old length. The bench uses four interrupt lines and two serial lines, so the OR across each vector is also exercised.

// File: rtl/pacer_pkg.sv
package pacer_pkg;

  // Width of the configuration write port and the positions of its fields
  localparam int CFG_W   = 3;
  localparam int SPD_LSB = 0;
  localparam int WAKE_BIT = 2;

  typedef enum logic [1:0] {
    SPD_FULL = 2'b00,
    SPD_SLOW1 = 2'b01,
    SPD_SLOW2 = 2'b10,
    SPD_SLOW3 = 2'b11
  } speed_e;

  function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                          input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/pacer_cfg_reg.sv
module pacer_cfg_reg
  import pacer_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             wake_fire,
  output speed_e           pend_speed,
  output logic             wake_en
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_speed <= SPD_FULL;
      wake_en    <= 1'b0;
    end else begin
      // A wake event overrides any speed written in the same clock
      if (wake_fire)
        pend_speed <= SPD_FULL;
      else if (cfg_wr)
        pend_speed <= speed_e'(cfg_wdata[SPD_LSB +: 2]);
      if (cfg_wr)
        wake_en <= cfg_wdata[WAKE_BIT];
    end
  end

endmodule

// File: rtl/pacer_wake.sv
module pacer_wake #(
  parameter int N_IRQ = 4,
  parameter int N_SER = 2
) (
  input  logic             wake_en,
  input  logic [N_IRQ-1:0] irq_req,
  input  logic [N_SER-1:0] ser_act,
  output logic             wake_fire
);

  logic any_irq;
  logic any_ser;

  assign any_irq   = |irq_req;
  assign any_ser   = |ser_act;
  assign wake_fire = wake_en & (any_irq | any_ser);

endmodule

// File: rtl/pacer_divider.sv
module pacer_divider
  import pacer_pkg::*;
#(
  parameter int unsigned RATIO0 = 1,
  parameter int unsigned RATIO1 = 4,
  parameter int unsigned RATIO2 = 64,
  parameter int unsigned RATIO3 = 1024,
  localparam int unsigned MAXR  = max_of4(RATIO0, RATIO1, RATIO2, RATIO3),
  localparam int CNT_W          = (MAXR > 1) ? $clog2(MAXR) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  speed_e           pend_speed,
  input  logic             wake_fire,
  output speed_e           act_speed,
  output logic [CNT_W-1:0] cnt,
  output logic             cyc_en
);

  localparam int unsigned RTAB [4] = '{RATIO0, RATIO1, RATIO2, RATIO3};

  logic [CNT_W-1:0] term_tab [4];
  logic             at_end;

  for (genvar g = 0; g < 4; g++) begin : g_term
    assign term_tab[g] = CNT_W'(RTAB[g] - 1);
  end

  assign at_end = (cnt == term_tab[act_speed]);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      act_speed <= SPD_FULL;
      cyc_en    <= 1'b0;
    end else if (wake_fire) begin
      cnt       <= '0;
      act_speed <= SPD_FULL;
      cyc_en    <= 1'b1;
    end else if (at_end) begin
      // Cycle boundary: the pending speed becomes active here
      cnt       <= '0;
      act_speed <= pend_speed;
      cyc_en    <= 1'b1;
    end else begin
      cnt       <= cnt + CNT_W'(1);
      cyc_en    <= 1'b0;
    end
  end

endmodule

// File: rtl/cycle_pace_unit.sv
module cycle_pace_unit
  import pacer_pkg::*;
#(
  parameter int unsigned RATIO0 = 1,
  parameter int unsigned RATIO1 = 4,
  parameter int unsigned RATIO2 = 64,
  parameter int unsigned RATIO3 = 1024,
  parameter int N_IRQ = 4,
  parameter int N_SER = 2,
  localparam int unsigned MAXR = max_of4(RATIO0, RATIO1, RATIO2, RATIO3),
  localparam int CNT_W         = (MAXR > 1) ? $clog2(MAXR) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic [N_IRQ-1:0] irq_req,
  input  logic [N_SER-1:0] ser_act,
  output logic             cyc_en
);

  speed_e           pend_speed;
  speed_e           act_speed;
  logic             wake_en;
  logic             wake_fire;
  logic [CNT_W-1:0] div_cnt;

  pacer_cfg_reg u_cfg (
    .clk       (clk),
    .rst       (rst),
    .cfg_wr    (cfg_wr),
    .cfg_wdata (cfg_wdata),
    .wake_fire (wake_fire),
    .pend_speed(pend_speed),
    .wake_en   (wake_en)
  );

  pacer_wake #(.N_IRQ(N_IRQ), .N_SER(N_SER)) u_wake (
    .wake_en  (wake_en),
    .irq_req  (irq_req),
    .ser_act  (ser_act),
    .wake_fire(wake_fire)
  );

  pacer_divider #(
    .RATIO0(RATIO0), .RATIO1(RATIO1), .RATIO2(RATIO2), .RATIO3(RATIO3)
  ) u_div (
    .clk       (clk),
    .rst       (rst),
    .pend_speed(pend_speed),
    .wake_fire (wake_fire),
    .act_speed (act_speed),
    .cnt       (div_cnt),
    .cyc_en    (cyc_en)
  );

endmodule

// File: rtl/cycle_pace_unit_chk.sv
module cycle_pace_unit_chk
  import pacer_pkg::*;
#(
  parameter int unsigned RATIO0 = 1,
  parameter int unsigned RATIO1 = 4,
  parameter int unsigned RATIO2 = 64,
  parameter int unsigned RATIO3 = 1024,
  parameter int N_IRQ = 4,
  parameter int N_SER = 2,
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_wr,
  input logic [N_IRQ-1:0] irq_req,
  input logic [N_SER-1:0] ser_act,
  input logic             cyc_en,
  input speed_e           pend_speed,
  input speed_e           act_speed,
  input logic             wake_en,
  input logic [CNT_W-1:0] div_cnt
);

  localparam int unsigned RTAB [4] = '{RATIO0, RATIO1, RATIO2, RATIO3};

  logic ev_any;
  assign ev_any = (|irq_req) | (|ser_act);

  // R2: the counter never passes the last count of the active ratio
  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (rst)
    32'(div_cnt) < RTAB[act_speed]);

  // R3: the strobe is one clock wide when the ratio exceeds one
  assert_pulse_narrow_R3: assert property (@(posedge clk) disable iff (rst)
    (cyc_en && RTAB[act_speed] > 1 && !(wake_en && ev_any)) |=> !cyc_en);

  // R4: the active speed changes only on a strobe clock
  assert_speed_at_edge_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(act_speed) |-> cyc_en);

  // R5: an enabled interrupt request gives a strobe on the next clock at full rate
  assert_irq_wake_R5: assert property (@(posedge clk) disable iff (rst)
    (wake_en && |irq_req) |=> (cyc_en && act_speed == SPD_FULL));

  // R6: an enabled serial event acts as a wake event
  assert_ser_wake_R6: assert property (@(posedge clk) disable iff (rst)
    (wake_en && |ser_act) |=> (cyc_en && act_speed == SPD_FULL));

  // R7: with the wake enable clear and no write, the speed field holds
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!wake_en && !cfg_wr) |=> $stable(pend_speed));

  // R8: a wake event beats a write made in the same clock
  assert_wake_prio_R8: assert property (@(posedge clk) disable iff (rst)
    (wake_en && ev_any && cfg_wr) |=> pend_speed == SPD_FULL);

endmodule

bind cycle_pace_unit cycle_pace_unit_chk #(
  .RATIO0(RATIO0), .RATIO1(RATIO1), .RATIO2(RATIO2), .RATIO3(RATIO3),
  .N_IRQ(N_IRQ), .N_SER(N_SER), .CNT_W(CNT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_wr    (cfg_wr),
  .irq_req   (irq_req),
  .ser_act   (ser_act),
  .cyc_en    (cyc_en),
  .pend_speed(pend_speed),
  .act_speed (act_speed),
  .wake_en   (wake_en),
  .div_cnt   (div_cnt)
);

// File: tb/cycle_pace_unit_test.sv
module cycle_pace_unit_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_wr = 1'b0;
  logic [2:0] cfg_wdata = '0;
  logic [3:0] irq_req = '0;
  logic [1:0] ser_act = '0;
  logic       cyc_en;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cycle_pace_unit uut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .irq_req(irq_req), .ser_act(ser_act), .cyc_en(cyc_en)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [1:0] spd, input logic wk);
    @(negedge clk);
    cfg_wr = 1'b1;
    cfg_wdata = {wk, spd};
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // Advance negedge by negedge until the strobe is seen
  task automatic wait_pulse();
    int n = 0;
    while (!cyc_en && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  // From a strobe negedge, count clocks to the next strobe
  task automatic gap(output int g);
    g = 0;
    do begin
      @(negedge clk);
      g++;
    end while (!cyc_en && g < 5000);
  endtask

  task automatic settle();
    int g;
    wait_pulse();
    gap(g);
    gap(g);
  endtask

  task automatic t_reset();
    int g;
    repeat (3) @(negedge clk);
    check(cyc_en == 1'b0, "R1 low in reset", cyc_en, 0);
    rst = 1'b0;
    @(negedge clk);
    check(cyc_en == 1'b1, "R1 strobe after reset", cyc_en, 1);
    gap(g);
    check(g == 1, "R2 speed 00 after reset", g, 1);
    gap(g);
    check(g == 1, "R2 speed 00 steady", g, 1);
  endtask

  task automatic t_ratios();
    int g;
    int exp_tab [4] = '{1, 4, 64, 1024};
    for (int m = 1; m < 4; m++) begin
      wr_cfg(2'(m), 1'b0);
      settle();
      gap(g);
      check(g == exp_tab[m], "R2 ratio", g, exp_tab[m]);
      @(negedge clk);
      check(cyc_en == 1'b0, "R3 strobe one clock wide", cyc_en, 0);
    end
    wr_cfg(2'b00, 1'b0);
    settle();
    gap(g);
    check(g == 1, "R2 back to speed 00", g, 1);
  endtask

  task automatic t_boundary();
    int n;
    int g;
    wr_cfg(2'b10, 1'b0);
    settle();
    n = 0;
    repeat (10) begin
      @(negedge clk);
      n++;
    end
    cfg_wr = 1'b1;
    cfg_wdata = 3'b000;
    @(negedge clk);
    n++;
    cfg_wr = 1'b0;
    while (!cyc_en && n < 5000) begin
      @(negedge clk);
      n++;
    end
    check(n == 64, "R4 running cycle keeps old length", n, 64);
    gap(g);
    check(g == 1, "R4 new ratio after boundary", g, 1);
  endtask

  task automatic t_wake_irq();
    int g;
    wr_cfg(2'b11, 1'b1);
    settle();
    repeat (20) @(negedge clk);
    irq_req = 4'b0100;
    @(negedge clk);
    irq_req = '0;
    check(cyc_en == 1'b1, "R5 strobe next clock on irq", cyc_en, 1);
    gap(g);
    check(g == 1, "R5 full rate after irq", g, 1);
    gap(g);
    check(g == 1, "R5 speed field cleared", g, 1);
  endtask

  task automatic t_wake_ser();
    int g;
    wr_cfg(2'b10, 1'b1);
    settle();
    repeat (7) @(negedge clk);
    ser_act = 2'b10;
    @(negedge clk);
    ser_act = '0;
    check(cyc_en == 1'b1, "R6 strobe next clock on serial", cyc_en, 1);
    gap(g);
    check(g == 1, "R6 full rate after serial", g, 1);
  endtask

  task automatic t_no_wake();
    int n;
    int g;
    wr_cfg(2'b10, 1'b0);
    settle();
    n = 0;
    repeat (5) begin
      @(negedge clk);
      n++;
    end
    irq_req = 4'b1111;
    ser_act = 2'b11;
    @(negedge clk);
    n++;
    irq_req = '0;
    ser_act = '0;
    while (!cyc_en && n < 5000) begin
      @(negedge clk);
      n++;
    end
    check(n == 64, "R7 events ignored when disabled", n, 64);
    gap(g);
    check(g == 64, "R7 ratio unchanged", g, 64);
  endtask

  task automatic t_prio();
    int g;
    wr_cfg(2'b01, 1'b1);
    settle();
    @(negedge clk);
    cfg_wr = 1'b1;
    cfg_wdata = 3'b111;
    irq_req = 4'b0001;
    @(negedge clk);
    cfg_wr = 1'b0;
    irq_req = '0;
    check(cyc_en == 1'b1, "R8 wake strobe", cyc_en, 1);
    gap(g);
    check(g == 1, "R8 wake beats write", g, 1);
    gap(g);
    check(g == 1, "R8 speed stays 00", g, 1);
    wr_cfg(2'b00, 1'b0);
  endtask

  initial begin
    t_reset();
    t_ratios();
    t_boundary();
    t_wake_irq();
    t_wake_ser();
    t_no_wake();
    t_prio();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule